// File: doc/BRIEF.md
# Macropixel Token-Scan Sparse Readout

This block drains a binary pixel matrix that is tiled into square groups of 4x4 pixels, called macropixels. Every macropixel has its own flag wire into a small queue at the foot of its macropixel column. The queue records which row of the column fired and the timestamp present when it fired. A token circulates over the column queues and picks the next queue that holds an entry. The block then collects the sixteen pixel bits of the macropixel that entry names, drops the pixels that are clear, and sends one word for each set pixel on a valid/ready stream.

Each output word holds the pixel column in its upper field, the pixel row in the middle and the stored timestamp in its low bits. If the stream stalls, the readout freezes in place and no data is lost. A one-cycle completion pulse marks the moment when every queue is empty and no macropixel is still being emitted. The matrix size in macropixels, the timestamp width and the queue depth are parameters.

Top module: `mpx_token_readout`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0, `qovf` is all zero and `frame_done` is 0. The first token search starts at macropixel column 0.
- R2: For each set pixel of a macropixel being read, the block emits exactly one word. The word is {pixel column, pixel row, timestamp}. The pixel column is `mp_col*4 + lc` and takes the upper `MCOL_W+2` bits. The pixel row is `mp_row*4 + lr` and takes the next `MROW_W+2` bits. The timestamp takes the low `TS_W` bits. Pixel (x,y) of the matrix is bit `y*PIX_COLS + x` of `pix_map`.
- R3: A macropixel whose sixteen bits are all clear is removed from its queue and produces no word.
- R4: The token serves the first non-empty queue at or after its pointer and wraps from the last column back to column 0. After it serves column g, its pointer moves to g+1 (or 0). A pass over empty queues costs no cycles.
- R5: Entries within one column are served oldest first. Each entry keeps the `ts_now` value from the cycle in which its flag was sampled.
- R6: A flag that arrives while its column queue holds `FIFO_DEPTH` entries is dropped. The `qovf` bit of that column then goes to 1 and stays at 1 until reset.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values into the next cycle.
- R8: `frame_done` is a single-cycle pulse. It is raised when the block moves from busy to the state in which all queues are empty and no macropixel remains to emit, and it is never raised while words are still owed.
- R9: When several macropixels of one column flag in the same cycle, only the lowest-numbered row is queued and the others are ignored.
- R10: Start from idle and flag a macropixel with at least one set pixel. `out_valid` is 0 after the edge that samples the flag, and 1 after the next edge, when it shows that macropixel's lowest set pixel.
- R11: Within a macropixel, words leave in increasing local index `lr*4+lc`, so row by row and left to right within a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mp_flag | input | MP_COLS*MP_ROWS | One hit flag per macropixel, bit `row*MP_COLS+col` |
| ts_now | input | TS_W | Current timestamp, captured with each queued flag |
| pix_map | input | MP_COLS*MP_ROWS*16 | Binary pixel matrix, held stable until its macropixel is read |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | MCOL_W+MROW_W+4+TS_W | {pixel column, pixel row, timestamp} |
| qovf | output | MP_COLS | Sticky per-column queue overflow |
| frame_done | output | 1 | Pulse on becoming idle |

## Verification
A flag is queued on the edge that samples it. The token loads that macropixel on the following edge, so its first word appears two edges after the flag. Each later word of the same macropixel follows one edge after the previous word is accepted, and `frame_done` rises in the cycle after the last word is taken. The bench samples every output at the falling edge and checks the two-edge latency in exactly those cycles. It holds `out_ready` low after the first macropixel loads, so every later flag is queued before any further token decision. This makes the reference model's serving order exact, and the bench compares every accepted word against that model in sequence.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
   localparam int MP_SIDE = 4;
   localparam int MP_PIX  = MP_SIDE * MP_SIDE;
   localparam int LIDX_W  = $clog2(MP_PIX);

   function automatic int safe_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/mpx_eoc_fifo.sv
module mpx_eoc_fifo #(
   parameter int DEPTH = 4,
   parameter int ROW_W = 2,
   parameter int TS_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ROW_W-1:0] push_row,
   input  logic [TS_W-1:0]  push_ts,
   input  logic             pop,
   output logic             empty,
   output logic [ROW_W-1:0] head_row,
   output logic [TS_W-1:0]  head_ts,
   output logic             ovf
);
   localparam int EW = ROW_W + TS_W;

   logic full;

   generate
      if (DEPTH == 1) begin : g_single
         logic          vld;
         logic [EW-1:0] ent;
         assign full  = vld;
         assign empty = !vld;
         assign {head_row, head_ts} = ent;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld <= 1'b0;
               ent <= '0;
            end else begin
               if (pop) vld <= 1'b0;
               if (push && !full) begin
                  vld <= 1'b1;
                  ent <= {push_row, push_ts};
               end
            end
         end
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         logic [EW-1:0] mem [DEPTH];
         logic [PW-1:0] wp, rp;
         logic [CW-1:0] cnt;
         logic          acc, take;
         assign full  = (cnt == CW'(DEPTH));
         assign empty = (cnt == '0);
         assign acc   = push && !full;
         assign take  = pop && !empty;
         assign {head_row, head_ts} = mem[rp];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else begin
               if (acc) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
               if (take) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
               if (acc && !take) cnt <= cnt + 1'b1;
               else if (take && !acc) cnt <= cnt - 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (acc) mem[wp] <= {push_row, push_ts};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ovf <= 1'b0;
      else if (push && full) ovf <= 1'b1;
   end
endmodule

// File: rtl/mpx_token_arb.sv
module mpx_token_arb #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   input  logic [IDX_W-1:0] ptr,
   output logic             any,
   output logic [IDX_W-1:0] gidx
);
   always_comb begin
      any  = 1'b0;
      gidx = '0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = int'(ptr) + k;
         if (j >= N) j = j - N;
         if (!any && req[j]) begin
            any  = 1'b1;
            gidx = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/mpx_sparsifier.sv
module mpx_sparsifier
   import mpx_pkg::*;
#(
   parameter int MCOL_W = 2,
   parameter int MROW_W = 2,
   parameter int TS_W   = 5,
   localparam int WORD_W = MCOL_W + MROW_W + 2 * 2 + TS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MP_PIX-1:0] load_bits,
   input  logic [MCOL_W-1:0] load_col,
   input  logic [MROW_W-1:0] load_row,
   input  logic [TS_W-1:0]   load_ts,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              busy
);
   logic [MP_PIX-1:0] mask;
   logic [MCOL_W-1:0] col_q;
   logic [MROW_W-1:0] row_q;
   logic [TS_W-1:0]   ts_q;
   logic [LIDX_W-1:0] lb;

   always_comb begin
      lb = '0;
      for (int k = MP_PIX - 1; k >= 0; k--) begin
         if (mask[k]) lb = LIDX_W'(k);
      end
   end

   assign busy      = |mask;
   assign out_valid = busy;
   assign out_data  = {col_q, lb[1:0], row_q, lb[3:2], ts_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask  <= '0;
         col_q <= '0;
         row_q <= '0;
         ts_q  <= '0;
      end else if (load) begin
         mask  <= load_bits;
         col_q <= load_col;
         row_q <= load_row;
         ts_q  <= load_ts;
      end else if (out_valid && out_ready) begin
         mask <= mask & (mask - 1'b1);
      end
   end
endmodule

// File: rtl/mpx_token_readout.sv
module mpx_token_readout
   import mpx_pkg::*;
#(
   parameter int MP_COLS    = 4,
   parameter int MP_ROWS    = 4,
   parameter int TS_W       = 5,
   parameter int FIFO_DEPTH = 4,
   localparam int MCOL_W   = safe_w(MP_COLS),
   localparam int MROW_W   = safe_w(MP_ROWS),
   localparam int PIX_COLS = MP_COLS * MP_SIDE,
   localparam int NMP      = MP_COLS * MP_ROWS,
   localparam int NPIX     = NMP * MP_PIX,
   localparam int WORD_W   = MCOL_W + MROW_W + 4 + TS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NMP-1:0]     mp_flag,
   input  logic [TS_W-1:0]    ts_now,
   input  logic [NPIX-1:0]    pix_map,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [WORD_W-1:0]  out_data,
   output logic [MP_COLS-1:0] qovf,
   output logic               frame_done
);
   generate
      if (MP_COLS < 1 || MP_ROWS < 1) begin : g_bad_size
         $error("matrix must hold at least one macropixel");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("queue depth must be at least one");
      end
      if (TS_W < 1) begin : g_bad_ts
         $error("timestamp width must be at least one");
      end
   endgenerate

   logic [MP_COLS-1:0] col_ne, col_pop;
   logic [MROW_W-1:0]  head_row [MP_COLS];
   logic [TS_W-1:0]    head_ts  [MP_COLS];
   logic [MCOL_W-1:0]  tok_ptr, grant;
   logic               any_ne, busy, take, idle, idle_q;
   logic [MP_PIX-1:0]  eor_bits;

   // per-column flag priority and end-of-column queue
   generate
      for (genvar c = 0; c < MP_COLS; c++) begin : g_col
         logic              fpush, fempty;
         logic [MROW_W-1:0] frow;
         always_comb begin
            fpush = 1'b0;
            frow  = '0;
            for (int r = MP_ROWS - 1; r >= 0; r--) begin
               if (mp_flag[r * MP_COLS + c]) begin
                  fpush = 1'b1;
                  frow  = MROW_W'(r);
               end
            end
         end
         mpx_eoc_fifo #(
            .DEPTH (FIFO_DEPTH),
            .ROW_W (MROW_W),
            .TS_W  (TS_W)
         ) i_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (fpush),
            .push_row (frow),
            .push_ts  (ts_now),
            .pop      (col_pop[c]),
            .empty    (fempty),
            .head_row (head_row[c]),
            .head_ts  (head_ts[c]),
            .ovf      (qovf[c])
         );
         assign col_ne[c]  = !fempty;
         assign col_pop[c] = take && (grant == MCOL_W'(c));
      end
   endgenerate

   mpx_token_arb #(
      .N     (MP_COLS),
      .IDX_W (MCOL_W)
   ) i_arb (
      .req  (col_ne),
      .ptr  (tok_ptr),
      .any  (any_ne),
      .gidx (grant)
   );

   assign take = any_ne && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) tok_ptr <= '0;
      else if (take) tok_ptr <= (grant == MCOL_W'(MP_COLS - 1)) ? '0 : grant + 1'b1;
   end

   // end-of-row gather of the selected macropixel
   always_comb begin
      for (int lr = 0; lr < MP_SIDE; lr++) begin
         for (int lc = 0; lc < MP_SIDE; lc++) begin
            eor_bits[lr * MP_SIDE + lc] =
               pix_map[(int'(head_row[grant]) * MP_SIDE + lr) * PIX_COLS
                       + int'(grant) * MP_SIDE + lc];
         end
      end
   end

   mpx_sparsifier #(
      .MCOL_W (MCOL_W),
      .MROW_W (MROW_W),
      .TS_W   (TS_W)
   ) i_sparse (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (take),
      .load_bits (eor_bits),
      .load_col  (grant),
      .load_row  (head_row[grant]),
      .load_ts   (head_ts[grant]),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .busy      (busy)
   );

   assign idle = !any_ne && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) idle_q <= 1'b1;
      else idle_q <= idle;
   end

   assign frame_done = idle && !idle_q;
endmodule

// File: rtl/mpx_token_readout_chk.sv
module mpx_token_readout_chk #(
   parameter int WORD_W = 13,
   parameter int NCOL   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_data,
   input logic [NCOL-1:0]   qovf,
   input logic              frame_done
);
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done); // R8
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !out_valid); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (qovf & $past(qovf)) == $past(qovf)); // R6
   AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$isunknown(out_data)); // R2
endmodule

bind mpx_token_readout mpx_token_readout_chk #(
   .WORD_W (WORD_W),
   .NCOL   (MP_COLS)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .qovf       (qovf),
   .frame_done (frame_done)
);

// File: tb/test_mpx_token_readout.sv
module test_mpx_token_readout;
   localparam int CLK_PERIOD = 10;
   localparam int C    = 4;
   localparam int R    = 4;
   localparam int TSW  = 5;
   localparam int D    = 4;
   localparam int NMP  = C * R;
   localparam int PXC  = C * 4;
   localparam int NPIX = NMP * 16;
   localparam int W    = 2 + 2 + 2 + 2 + TSW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NMP-1:0]  mp_flag = '0;
   logic [TSW-1:0]  ts_now = '0;
   logic [NPIX-1:0] pix_map = '0;
   logic            out_valid, out_ready = 1'b0;
   logic [W-1:0]    out_data;
   logic [C-1:0]    qovf;
   logic            frame_done;

   int n_chk = 0, n_fail = 0;
   int mode = 0, fd_cnt = 0, ptr_m = 0;
   logic [C-1:0] ovf_exp = '0;
   logic [W-1:0] exp_q[$];
   int qr [C][$];
   int qt [C][$];
   logic pv = 0, pr = 0;
   logic [W-1:0] pd = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mpx_token_readout #(
      .MP_COLS (C), .MP_ROWS (R), .TS_W (TSW), .FIFO_DEPTH (D)
   ) i_mpx_token_readout (
      .clk (clk), .rst_n (rst_n), .mp_flag (mp_flag), .ts_now (ts_now),
      .pix_map (pix_map), .out_valid (out_valid), .out_ready (out_ready),
      .out_data (out_data), .qovf (qovf), .frame_done (frame_done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exv);
      end
   endtask

   function automatic logic [W-1:0] mkword(int c, int r, int t, int b);
      logic [3:0] x, y;
      x = 4'(c * 4 + b % 4);
      y = 4'(r * 4 + b / 4);
      return {x, y, TSW'(t)};
   endfunction

   function automatic void model_push(int c, int r, int t);
      if (qr[c].size() >= D) ovf_exp[c] = 1'b1;
      else begin
         qr[c].push_back(r);
         qt[c].push_back(t);
      end
   endfunction

   function automatic void model_flags(logic [NMP-1:0] v, int t);
      for (int c = 0; c < C; c++) begin
         for (int r = 0; r < R; r++) begin
            if (v[r * C + c]) begin
               model_push(c, r, t);
               break;
            end
         end
      end
   endfunction

   function automatic void serve();
      for (int k = 0; k < C; k++) begin
         int c;
         c = (ptr_m + k) % C;
         if (qr[c].size() > 0) begin
            int r, t;
            r = qr[c].pop_front();
            t = qt[c].pop_front();
            for (int b = 0; b < 16; b++)
               if (pix_map[(r * 4 + b / 4) * PXC + c * 4 + b % 4]) exp_q.push_back(mkword(c, r, t, b));
            ptr_m = (c + 1) % C;
            return;
         end
      end
   endfunction

   function automatic bit model_empty();
      for (int c = 0; c < C; c++) if (qr[c].size() > 0) return 1'b0;
      return 1'b1;
   endfunction

   task automatic tick();
      @(negedge clk);
      if (pv && !pr)
         chk(out_valid && out_data == pd, "R7 stalled word changed", 32'(out_data), 32'(pd));
      case (mode)
         0: out_ready = 1'b0;
         1: out_ready = ($urandom % 4) != 0;
         default: out_ready = 1'b1;
      endcase
      if (out_valid && out_ready) begin
         if (exp_q.size() == 0)
            chk(1'b0, "R3 R2 unexpected word", 32'(out_data), 32'hffffffff);
         else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(out_data == e, "R2 R4 R5 R9 R11 word", 32'(out_data), 32'(e));
         end
      end
      if (frame_done) begin
         fd_cnt++;
         chk(exp_q.size() == 0, "R8 done while words owed", 32'(exp_q.size()), 0);
      end
      pv = out_valid;
      pr = out_ready;
      pd = out_data;
   endtask

   task automatic scenario(int ncyc, int dens, bit zero_mp, bit burst, int ovf_col, int dmode);
      int c0, r0, t0, guard;
      logic [NMP-1:0] v;
      mode = 0;
      fd_cnt = 0;
      for (int i = 0; i < NPIX; i++) pix_map[i] = (($urandom % 100) < dens);
      c0 = $urandom % C;
      r0 = $urandom % R;
      t0 = $urandom % (1 << TSW);
      pix_map[(r0 * 4 + ($urandom % 4)) * PXC + c0 * 4 + ($urandom % 4)] = 1'b1;
      if (zero_mp)
         for (int b = 0; b < 16; b++) pix_map[(0 * 4 + b / 4) * PXC + ((c0 + 1) % C) * 4 + b % 4] = 1'b0;
      tick();
      mp_flag = '0;
      mp_flag[r0 * C + c0] = 1'b1;
      ts_now = TSW'(t0);
      tick();
      chk(out_valid == 1'b0, "R10 valid one edge after flag", 32'(out_valid), 0);
      mp_flag = '0;
      model_push(c0, r0, t0);
      serve();
      tick();
      chk(out_valid == 1'b1 && out_data == exp_q[0], "R10 first word two edges after flag",
          32'(out_data), 32'(exp_q[0]));
      tick();
      for (int cyc = 0; cyc < ncyc; cyc++) begin
         int t;
         v = '0;
         for (int m = 0; m < NMP; m++) v[m] = ($urandom % 6) == 0;
         if (cyc == 0 && zero_mp) v[0 * C + (c0 + 1) % C] = 1'b1;
         if (cyc == 0 && burst) for (int r = 0; r < R; r++) v[r * C + (c0 + 2) % C] = 1'b1;
         if (ovf_col >= 0) v[(cyc % R) * C + ovf_col] = 1'b1;
         t = $urandom % (1 << TSW);
         mp_flag = v;
         ts_now = TSW'(t);
         tick();
         model_flags(v, t);
      end
      mp_flag = '0;
      while (!model_empty()) serve();
      mode = dmode;
      guard = 0;
      while ((exp_q.size() != 0 || out_valid) && guard < 4000) begin
         tick();
         guard++;
      end
      repeat (4) tick();
      chk(exp_q.size() == 0, "R2 words missing", 32'(exp_q.size()), 0);
      chk(fd_cnt == 1, "R8 frame_done pulse count", 32'(fd_cnt), 1);
      chk(qovf == ovf_exp, "R6 overflow flags", 32'(qovf), 32'(ovf_exp));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0 && qovf == '0 && frame_done == 1'b0, "R1 reset state",
          {out_valid, frame_done, 26'd0, qovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && qovf == '0 && frame_done == 1'b0, "R1 after reset",
          {out_valid, frame_done, 26'd0, qovf}, 0);
      scenario(3, 30, 1'b0, 1'b0, -1, 2);
      scenario(2, 30, 1'b1, 1'b0, -1, 2);   // R3 empty macropixel
      scenario(2, 25, 1'b0, 1'b1, -1, 1);   // R9 column burst, R4 wrap
      scenario(3, 20, 1'b1, 1'b1, -1, 1);
      for (int s = 0; s < 8; s++) scenario(2 + s % 4, 10 + 5 * s, 1'b0, s[0], -1, 1);
      scenario(D + 3, 20, 1'b0, 1'b0, 2, 1); // R6 queue overflow
      scenario(4, 35, 1'b1, 1'b0, -1, 2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule